// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block decides when a receive queue should interrupt its host. It keeps its own tally of the frames and bytes that are waiting. It also times how long the oldest waiting frame has been there, counting in microsecond ticks. It compares those three figures against three thresholds. Each threshold can be switched on or off by itself. When an enabled figure first goes past its threshold, a sticky interrupt status bit is set. The host clears that bit by writing 1 to it.

The queue reports each enqueued frame with its length. The host side reports each dequeued frame with its length. Both event streams are never back-pressured: there is no ready signal, and a valid pulse is taken in the cycle it is seen. A dequeue that arrives while the tally is empty is dropped. If no threshold is enabled, every enqueued frame sets the interrupt by itself. Each threshold also drives its own live status flag, so the host can tell which condition fired.

Top module: `rx_coalesce`

## Requirements
- R1: While reset is held and just after it, the frame, byte and time tallies are zero, and `rx_irq`, `frm_flag`, `byte_flag` and `dur_flag` are all 0.
- R2: `frm_flag` is 1 exactly when `cfg_frm_en` is 1 and the queued frame count is strictly greater than `cfg_frm_thr`.
- R3: `byte_flag` is 1 exactly when `cfg_byte_en` is 1 and the queued byte count is strictly greater than the 16-bit `cfg_byte_thr`.
- R4: The elapsed-time tally starts at zero when a frame enters an empty queue. It gains one for each `tick_us` pulse while the queue is non-empty. `dur_flag` is 1 exactly when `cfg_dur_en` is 1 and the tally is strictly greater than the effective duration threshold.
- R5: When the queue becomes empty, the elapsed-time tally returns to zero. It starts again from zero on the next enqueue.
- R6: The effective duration threshold is `cfg_dur_thr`, except that any value above the ceiling `DUR_MAX` (default 0xCFFF) acts as `DUR_MAX`.
- R7: `rx_irq` is set at the first clock edge at which an enabled flag is seen at 1 after having been 0 at the edge before.
- R8: With all three enables at 0, `rx_irq` is set at the same clock edge that takes in an enqueue.
- R9: `rx_irq` stays at 1 until a cycle with `irq_clr` at 1, and it reads 0 after that edge. If a set condition occurs in that same cycle, the set wins.
- R10: An enqueue and a dequeue in the same cycle on a non-empty queue leave the frame count unchanged. They change the byte count by `enq_len - deq_len`.
- R11: A dequeue while the queue is empty is ignored. The byte count never goes below zero, and it is zero whenever the frame count is zero.
- R12: The three enables act independently, and any combination of them may be active at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | One frame entered the queue this cycle |
| enq_len | input | LEN_W | Byte length of the entering frame |
| deq_valid | input | 1 | The host removed one frame this cycle |
| deq_len | input | LEN_W | Byte length of the removed frame |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| cfg_frm_en | input | 1 | Enable for the frame-count condition |
| cfg_byte_en | input | 1 | Enable for the byte-count condition |
| cfg_dur_en | input | 1 | Enable for the elapsed-time condition |
| cfg_frm_thr | input | FRM_W | Frame-count threshold |
| cfg_byte_thr | input | BTHR_W | Byte-count threshold |
| cfg_dur_thr | input | DUR_W | Elapsed-time threshold in microseconds |
| irq_clr | input | 1 | Write-1 clear of the interrupt status |
| rx_irq | output | 1 | Sticky receive interrupt status |
| frm_flag | output | 1 | Frame-count condition met |
| byte_flag | output | 1 | Byte-count condition met |
| dur_flag | output | 1 | Elapsed-time condition met |

## Verification
The bench keeps the default widths: 12-bit frame count, 24-bit byte count, 16-bit lengths and thresholds, and a 16-bit timer. It lowers `DUR_MAX` to 40. With that ceiling, a written duration threshold of 1000 is clamped and fires after 41 ticks instead of thousands, so the clamp can be shown directly. The random phase can then cross the ceiling often while still raising ticks, enables and clears in every mix.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int NCOND = 3;
  localparam int C_FRM  = 0;
  localparam int C_BYTE = 1;
  localparam int C_DUR  = 2;
  typedef logic [NCOND-1:0] rxc_cond_t;
endpackage

// File: rtl/rxc_tally.sv
module rxc_tally #(
  parameter int FRM_W  = 12,
  parameter int BYTE_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [LEN_W-1:0]  enq_len,
  input  logic              deq_valid,
  input  logic [LEN_W-1:0]  deq_len,
  output logic [FRM_W-1:0]  frm_cnt,
  output logic [BYTE_W-1:0] byte_cnt,
  output logic              empty_next
);
  localparam int SUM_W = BYTE_W + 1;

  logic              deq_ok;
  logic [FRM_W-1:0]  frm_d;
  logic [SUM_W-1:0]  add_v, sub_v;
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    deq_ok     = deq_valid && (frm_cnt != '0);
    frm_d      = frm_cnt + FRM_W'(enq_valid) - FRM_W'(deq_ok);
    empty_next = (frm_d == '0);
    add_v      = SUM_W'(byte_cnt) + (enq_valid ? SUM_W'(enq_len) : '0);
    sub_v      = deq_ok ? SUM_W'(deq_len) : '0;
    if (empty_next || (sub_v >= add_v)) byte_d = '0;
    else                                 byte_d = BYTE_W'(add_v - sub_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_cnt  <= '0;
      byte_cnt <= '0;
    end else begin
      frm_cnt  <= frm_d;
      byte_cnt <= byte_d;
    end
  end
endmodule

// File: rtl/rxc_dur_timer.sv
module rxc_dur_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic             busy,
  input  logic             empty_next,
  output logic [DUR_W-1:0] dur_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                                       dur_cnt <= '0;
    else if (empty_next)                              dur_cnt <= '0;
    else if (tick_us && busy && (dur_cnt != '1))      dur_cnt <= dur_cnt + 1'b1;
  end
endmodule

// File: rtl/rxc_irq_gen.sv
module rxc_irq_gen
  import rxc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rxc_cond_t cond,
  input  logic      every_frame,
  input  logic      irq_clr,
  output logic      rx_irq
);
  rxc_cond_t prev_q;
  rxc_cond_t rise;

  for (genvar i = 0; i < NCOND; i++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= cond[i];
    end
    assign rise[i] = cond[i] && !prev_q[i];
  end

  logic set_now;
  assign set_now = (|rise) || every_frame;

  always_ff @(posedge clk) begin
    if (!rst_n)       rx_irq <= 1'b0;
    else if (set_now) rx_irq <= 1'b1;
    else if (irq_clr) rx_irq <= 1'b0;
  end
endmodule

// File: rtl/rx_coalesce.sv
module rx_coalesce
  import rxc_pkg::*;
#(
  parameter int FRM_W   = 12,
  parameter int BYTE_W  = 24,
  parameter int LEN_W   = 16,
  parameter int BTHR_W  = 16,
  parameter int DUR_W   = 16,
  parameter int DUR_MAX = 'hCFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [LEN_W-1:0]  enq_len,
  input  logic              deq_valid,
  input  logic [LEN_W-1:0]  deq_len,
  input  logic              tick_us,
  input  logic              cfg_frm_en,
  input  logic              cfg_byte_en,
  input  logic              cfg_dur_en,
  input  logic [FRM_W-1:0]  cfg_frm_thr,
  input  logic [BTHR_W-1:0] cfg_byte_thr,
  input  logic [DUR_W-1:0]  cfg_dur_thr,
  input  logic              irq_clr,
  output logic              rx_irq,
  output logic              frm_flag,
  output logic              byte_flag,
  output logic              dur_flag
);
  localparam logic [DUR_W-1:0] DUR_CAP = DUR_W'(DUR_MAX);
  localparam int PAD_W = BYTE_W - BTHR_W;

  logic [FRM_W-1:0]  frm_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic [DUR_W-1:0]  dur_cnt;
  logic              empty_next;
  logic [DUR_W-1:0]  dur_thr_eff;
  rxc_cond_t         cond;
  logic              every_frame;

  rxc_tally #(.FRM_W(FRM_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (enq_valid),
    .enq_len    (enq_len),
    .deq_valid  (deq_valid),
    .deq_len    (deq_len),
    .frm_cnt    (frm_cnt),
    .byte_cnt   (byte_cnt),
    .empty_next (empty_next)
  );

  rxc_dur_timer #(.DUR_W(DUR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .busy       (frm_cnt != '0),
    .empty_next (empty_next),
    .dur_cnt    (dur_cnt)
  );

  assign dur_thr_eff = (cfg_dur_thr > DUR_CAP) ? DUR_CAP : cfg_dur_thr;

  assign frm_flag  = cfg_frm_en  && (frm_cnt > cfg_frm_thr);
  assign byte_flag = cfg_byte_en && (byte_cnt > {{PAD_W{1'b0}}, cfg_byte_thr});
  assign dur_flag  = cfg_dur_en  && (dur_cnt > dur_thr_eff);

  always_comb begin
    cond         = '0;
    cond[C_FRM]  = frm_flag;
    cond[C_BYTE] = byte_flag;
    cond[C_DUR]  = dur_flag;
  end

  assign every_frame = enq_valid && !(cfg_frm_en || cfg_byte_en || cfg_dur_en);

  rxc_irq_gen u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond        (cond),
    .every_frame (every_frame),
    .irq_clr     (irq_clr),
    .rx_irq      (rx_irq)
  );
endmodule

// File: rtl/rxc_chk.sv
module rxc_chk #(
  parameter int FRM_W = 12,
  parameter int DUR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enq_valid,
  input logic             deq_valid,
  input logic             irq_clr,
  input logic             cfg_frm_en,
  input logic             cfg_byte_en,
  input logic             cfg_dur_en,
  input logic             rx_irq,
  input logic             byte_flag,
  input logic             dur_flag,
  input logic [FRM_W-1:0] frm_cnt,
  input logic [DUR_W-1:0] dur_cnt
);
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !irq_clr) |=> rx_irq);
  // R8
  every_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !cfg_frm_en && !cfg_byte_en && !cfg_dur_en) |=> rx_irq);
  // R7
  byte_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_flag) |=> rx_irq);
  // R7
  dur_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dur_flag) |=> rx_irq);
  // R5
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_cnt == '0) |-> (dur_cnt == '0));
  // R10
  both_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && deq_valid && frm_cnt != '0) |=> $stable(frm_cnt));
  // R11
  empty_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_valid && !enq_valid && frm_cnt == '0) |=> (frm_cnt == '0));
endmodule

bind rx_coalesce rxc_chk #(.FRM_W(FRM_W), .DUR_W(DUR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enq_valid   (enq_valid),
  .deq_valid   (deq_valid),
  .irq_clr     (irq_clr),
  .cfg_frm_en  (cfg_frm_en),
  .cfg_byte_en (cfg_byte_en),
  .cfg_dur_en  (cfg_dur_en),
  .rx_irq      (rx_irq),
  .byte_flag   (byte_flag),
  .dur_flag    (dur_flag),
  .frm_cnt     (frm_cnt),
  .dur_cnt     (dur_cnt)
);

// File: tb/tb_rx_coalesce.sv
`timescale 1ns/1ps
module tb_rx_coalesce;
  localparam int CAP = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 0, deq_valid = 0, tick_us = 0, irq_clr = 0;
  logic [15:0] enq_len = 0, deq_len = 0;
  logic        cfg_frm_en = 0, cfg_byte_en = 0, cfg_dur_en = 0;
  logic [11:0] cfg_frm_thr = 12'd3;
  logic [15:0] cfg_byte_thr = 16'd1000;
  logic [15:0] cfg_dur_thr = 16'd10;
  logic        rx_irq, frm_flag, byte_flag, dur_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rx_coalesce #(.DUR_MAX(CAP)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_len(enq_len),
    .deq_valid(deq_valid), .deq_len(deq_len), .tick_us(tick_us),
    .cfg_frm_en(cfg_frm_en), .cfg_byte_en(cfg_byte_en), .cfg_dur_en(cfg_dur_en),
    .cfg_frm_thr(cfg_frm_thr), .cfg_byte_thr(cfg_byte_thr), .cfg_dur_thr(cfg_dur_thr),
    .irq_clr(irq_clr), .rx_irq(rx_irq), .frm_flag(frm_flag),
    .byte_flag(byte_flag), .dur_flag(dur_flag)
  );

  // Behavioural reference state
  int m_frames, m_bytes, m_time;
  bit m_irq, m_pf, m_pb, m_pd;

  function automatic bit mf();
    return cfg_frm_en && (m_frames > int'(cfg_frm_thr));
  endfunction
  function automatic bit mb();
    return cfg_byte_en && (m_bytes > int'(cfg_byte_thr));
  endfunction
  function automatic bit md();
    int lim;
    lim = (int'(cfg_dur_thr) > CAP) ? CAP : int'(cfg_dur_thr);
    return cfg_dur_en && (m_time > lim);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit fn, bn, dn, set, dok;
    int nf, add, sub, nb;
    if (!rst_n) begin
      m_frames = 0; m_bytes = 0; m_time = 0;
      m_irq = 0; m_pf = 0; m_pb = 0; m_pd = 0;
    end else begin
      fn = mf(); bn = mb(); dn = md();
      set = (fn && !m_pf) || (bn && !m_pb) || (dn && !m_pd) ||
            (enq_valid && !cfg_frm_en && !cfg_byte_en && !cfg_dur_en);
      if (set) m_irq = 1; else if (irq_clr) m_irq = 0;
      m_pf = fn; m_pb = bn; m_pd = dn;
      dok = deq_valid && (m_frames > 0);
      nf  = m_frames + (enq_valid ? 1 : 0) - (dok ? 1 : 0);
      add = m_bytes + (enq_valid ? int'(enq_len) : 0);
      sub = dok ? int'(deq_len) : 0;
      nb  = (nf == 0 || sub >= add) ? 0 : add - sub;
      if (nf == 0) m_time = 0;
      else if (tick_us && m_frames > 0 && m_time < 65535) m_time = m_time + 1;
      m_frames = nf; m_bytes = nb;
    end
  end

  // Per-clock comparison against the model (R2, R3, R4, R6, R9, R12)
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R9 rx_irq", rx_irq, m_irq);
      chk("R2 frm_flag", frm_flag, mf());
      chk("R3 byte_flag", byte_flag, mb());
      chk("R4 dur_flag", dur_flag, md());
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enq_valid = 0; deq_valid = 0; tick_us = 0; irq_clr = 0;
    end
  endtask

  task automatic ev(bit e, int el, bit d, int dl, bit t, bit c);
    @(negedge clk);
    enq_valid = e; enq_len = 16'(el); deq_valid = d; deq_len = 16'(dl);
    tick_us = t; irq_clr = c;
  endtask

  task automatic clear_irq();
    ev(0, 0, 0, 0, 0, 1);
    idle(1);
  endtask

  task automatic drain();
    while (m_frames > 0) ev(0, 0, 1, 0, 0, 0);
    idle(1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 flags", {frm_flag, byte_flag, dur_flag}, 0);
    rst_n = 1;
    idle(2);
    chk("R1 after reset", {rx_irq, frm_flag, byte_flag, dur_flag}, 0);

    // R8: no enables, each enqueue sets the interrupt
    ev(1, 100, 0, 0, 0, 0);
    idle(1);
    chk("R8 irq on enqueue", rx_irq, 1);
    // R9: write-1 clear
    clear_irq();
    chk("R9 cleared", rx_irq, 0);
    // R9: set beats clear in same cycle
    ev(1, 50, 0, 0, 0, 1);
    idle(1);
    chk("R9 set wins", rx_irq, 1);
    clear_irq();
    drain();

    // R2 / R7: frame threshold 2
    cfg_frm_en = 1; cfg_frm_thr = 12'd2;
    ev(1, 64, 0, 0, 0, 0);
    ev(1, 64, 0, 0, 0, 0);
    idle(2);
    chk("R2 at threshold", frm_flag, 0);
    ev(1, 64, 0, 0, 0, 0);
    idle(1);
    chk("R2 above threshold", frm_flag, 1);
    chk("R7 irq one edge later", rx_irq, 0);
    idle(1);
    chk("R7 irq raised", rx_irq, 1);
    // R10: enqueue and dequeue together
    ev(1, 200, 1, 64, 0, 0);
    idle(1);
    chk("R10 frames kept", frm_flag, 1);
    clear_irq();
    drain();
    chk("R11 empty after drain", frm_flag, 0);
    cfg_frm_en = 0;

    // R3: byte threshold, with frame enable also on (R12)
    cfg_byte_en = 1; cfg_byte_thr = 16'd1000; cfg_frm_en = 1; cfg_frm_thr = 12'd50;
    ev(1, 600, 0, 0, 0, 0);
    ev(1, 400, 0, 0, 0, 0);
    idle(1);
    chk("R3 equal not above", byte_flag, 0);
    ev(1, 1, 0, 0, 0, 0);
    idle(1);
    chk("R3 above", byte_flag, 1);
    idle(1);
    chk("R12 byte irq with frm enabled", rx_irq, 1);
    clear_irq();
    drain();
    cfg_byte_en = 0; cfg_frm_en = 0;

    // R4 / R5: duration threshold 5
    cfg_dur_en = 1; cfg_dur_thr = 16'd5;
    ev(1, 80, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) ev(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R4 five ticks", dur_flag, 0);
    ev(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R4 six ticks", dur_flag, 1);
    clear_irq();
    ev(0, 0, 1, 80, 0, 0);
    idle(1);
    chk("R5 reset on empty", dur_flag, 0);
    ev(1, 80, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) ev(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R5 restart from zero", dur_flag, 0);
    drain();

    // R6: clamp of duration threshold to the ceiling
    cfg_dur_thr = 16'd1000;
    clear_irq();
    ev(1, 80, 0, 0, 0, 0);
    for (int i = 0; i < CAP; i++) ev(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R6 at ceiling", dur_flag, 0);
    ev(0, 0, 0, 0, 1, 0);
    idle(1);
    chk("R6 above ceiling", dur_flag, 1);
    idle(1);
    chk("R6 irq", rx_irq, 1);
    drain();
    cfg_dur_en = 0;
    clear_irq();

    // R11: dequeue on empty queue ignored
    cfg_frm_en = 1; cfg_frm_thr = 12'd0;
    ev(0, 0, 1, 500, 0, 0);
    idle(1);
    chk("R11 no underflow", frm_flag, 0);
    ev(1, 10, 0, 0, 0, 0);
    idle(1);
    chk("R11 one frame after empty dequeue", frm_flag, 1);
    drain();
    cfg_frm_en = 0;
    clear_irq();

    // R12: random mixes of enables, ticks, clears and events
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        @(negedge clk);
        cfg_frm_en   = 1'($urandom);
        cfg_byte_en  = 1'($urandom);
        cfg_dur_en   = 1'($urandom);
        cfg_frm_thr  = 12'($urandom_range(0, 6));
        cfg_byte_thr = 16'($urandom_range(0, 4000));
        cfg_dur_thr  = 16'($urandom_range(0, 80));
      end
      ev(($urandom % 3) == 0, $urandom_range(1, 1500),
         ($urandom % 3) == 0, $urandom_range(0, 1500),
         ($urandom % 2) == 0, ($urandom % 9) == 0);
    end
    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule